// File: doc/BRIEF.md
# Limited-Pointer Coherence Directory Controller

This block is the memory-side directory for one home node of a distributed shared-memory machine. For every memory block it homes, it keeps one directory entry. An entry holds a coherence state, a trap-on-write mode flag, an invalidation acknowledge counter and a small fixed set of sharer pointers. Caches send coherence requests tagged with their node ID. The controller answers with data grants, busy replies or invalidations, each addressed to a node ID.

The block works with the four states below. Read-Only and Read-Write are the stable states. In Read-Transaction, a read is held until the old owner gives the line back. In Write-Transaction, a write is held until every invalidation has been acknowledged.

The entry can run out of pointers when one more reader arrives. In that case the controller neither evicts a sharer nor answers the read. It consumes the request and pulses a trap toward the local processor. The trap handler then uses a small write port to rewrite the entry. Through that port it can clear the pointers, set the state, the counter and the mode, and seed one requester. While an entry is in trap-on-write mode, a write request is trapped in the same way.

All outgoing messages leave through one valid/ready port, one per transfer. Invalidations to several sharers go out one after another, and request intake stalls until the last of them has been issued.

Top module: `lpdir_ctrl`

## Requirements
- R1: After reset, every entry is in Read-Only with no sharers, normal mode and a counter of 0. After reset, out_valid and trap_pulse are 0 and req_ready is 1.
- R2: Request codes on req_kind are read 0, write 1, replace 2, update 3 and acknowledge 4. In Read-Only, a read from node i returns RDATA to i. If i is not yet a sharer, i is stored in the lowest free pointer slot; a node that is already a sharer is never stored twice.
- R3: In Read-Only, a write from i when no node other than i is a sharer leaves i as the only sharer, returns WDATA to i and enters Read-Write.
- R4: In Read-Only, a write from i while other sharers exist does the following: it sends INV to each other sharer, in ascending pointer-slot order. It loads the counter with the number of INVs, leaves i as the only sharer and enters Write-Transaction. The first INV becomes valid two cycles after acceptance.
- R5: In Read-Write with owner o, a read or write from another node j sends INV to o, sets the counter to 1, leaves j as the only sharer, and enters Read-Transaction (read) or Write-Transaction (write). A read or write from o itself returns RDATA or WDATA to o and changes nothing.
- R6: In Read-Write, a replace from the owner empties the sharer set and enters Read-Only with no output. A replace from any other node has no effect. An update or acknowledge in Read-Only or Read-Write has no effect.
- R7: In Read-Transaction or Write-Transaction, a read or write gets BUSY back to the requester and a replace has no effect.
- R8: In Write-Transaction, an acknowledge with the counter above 1 decrements the counter with no output. An acknowledge with the counter at 1 or below, or any update, clears the counter, sends WDATA to the held requester and enters Read-Write.
- R9: In Read-Transaction, an acknowledge or update sends RDATA to the held requester. The entry enters Read-Only, with that requester as the only sharer.
- R10: In Read-Only, a read from a new node while all NPTR slots are full sends no message and leaves the entry unchanged. On the next cycle it pulses trap_pulse with trap_cause 0 (overflow), and trap_node and trap_blk name the request.
- R11: In trap-on-write mode, a write in Read-Only sends no message, leaves the entry unchanged and pulses trap_pulse with trap_cause 1. Reads in this mode are serviced as in R2.
- R12: State codes on cfg_state are Read-Only 0, Read-Write 1, Read-Transaction 2 and Write-Transaction 3. A cycle with cfg_we writes the state, mode and counter of entry cfg_blk and clears its pointers. If cfg_node_en is set, it stores cfg_node in slot 0. req_ready is 0 during that cycle.
- R13: Message codes on out_kind are RDATA 0, WDATA 1, INV 2 and BUSY 3. Each handshake carries one message, and a stalled message holds stable. A direct reply becomes valid the cycle after its request is accepted. req_ready is 0 while INVs are pending or while an unaccepted message is held.
- R14: Each block number has its own entry, so a request to one block leaves all other entries unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted at this edge when valid |
| req_kind | input | 3 | Request code (R2) |
| req_src | input | NODE_W | Requesting node ID |
| req_blk | input | BLK_W | Block number |
| out_valid | output | 1 | Outgoing message present |
| out_ready | input | 1 | Network takes the message |
| out_kind | output | 2 | Message code (R13) |
| out_dst | output | NODE_W | Destination node |
| out_blk | output | BLK_W | Block the message refers to |
| trap_pulse | output | 1 | One-cycle trap to the local processor |
| trap_cause | output | 1 | 0 pointer overflow, 1 write in trap mode |
| trap_node | output | NODE_W | Requester that caused the trap |
| trap_blk | output | BLK_W | Block that caused the trap |
| cfg_we | input | 1 | Handler write strobe |
| cfg_blk | input | BLK_W | Entry to write |
| cfg_state | input | 2 | New state (R12) |
| cfg_trapmode | input | 1 | New trap-on-write mode |
| cfg_ctr | input | CTR_W | New acknowledge counter |
| cfg_node_en | input | 1 | Store cfg_node in slot 0 |
| cfg_node | input | NODE_W | Node to store |

## Verification
The result of an accepted request is visible one cycle later, whether it is a direct reply, a BUSY or a trap pulse. Multi-target invalidations start one cycle after that and then advance one per completed handshake. The bench drives on the falling edge. In the falling edge right after the accepting edge, it checks that a reply is valid, or that nothing was sent and trap_pulse has the expected value. A behavioural model queues the expected messages, and every transfer is compared against the head of that queue at the falling edge before the edge that completes the transfer. Some phases apply back-pressure on every second cycle, so that the checks also cover ordering and holding while a message is stalled.

// File: rtl/lpdir_pkg.sv
package lpdir_pkg;
  typedef enum logic [1:0] {
    ST_RO = 2'd0,
    ST_RW = 2'd1,
    ST_RT = 2'd2,
    ST_WT = 2'd3
  } dir_state_e;

  typedef enum logic [2:0] {
    RQ_READ    = 3'd0,
    RQ_WRITE   = 3'd1,
    RQ_REPLACE = 3'd2,
    RQ_UPDATE  = 3'd3,
    RQ_ACK     = 3'd4
  } req_kind_e;

  typedef enum logic [1:0] {
    MS_RDATA = 2'd0,
    MS_WDATA = 2'd1,
    MS_INV   = 2'd2,
    MS_BUSY  = 2'd3
  } msg_kind_e;
endpackage

// File: rtl/lpdir_ptrs.sv
module lpdir_ptrs #(
  parameter int NPTR   = 4,
  parameter int NODE_W = 6,
  parameter int CNT_W  = 3
) (
  input  logic [NPTR-1:0]             ptr_v,
  input  logic [NPTR-1:0][NODE_W-1:0] ptr_id,
  input  logic [NODE_W-1:0]           node,
  output logic                        hit,
  output logic [NPTR-1:0]             free_vec,
  output logic                        full,
  output logic [NPTR-1:0]             others,
  output logic [CNT_W-1:0]            others_cnt,
  output logic [NODE_W-1:0]           first_id
);
  logic [NPTR-1:0] hit_vec;
  logic            seen_free;

  always_comb begin
    hit_vec    = '0;
    free_vec   = '0;
    seen_free  = 1'b0;
    others_cnt = '0;
    first_id   = '0;
    for (int k = 0; k < NPTR; k++) begin
      hit_vec[k] = ptr_v[k] && (ptr_id[k] == node);
      if (!ptr_v[k] && !seen_free) begin
        free_vec[k] = 1'b1;
        seen_free   = 1'b1;
      end
    end
    others = ptr_v & ~hit_vec;
    for (int k = 0; k < NPTR; k++)
      others_cnt = others_cnt + CNT_W'(others[k]);
    for (int k = NPTR - 1; k >= 0; k--)
      if (ptr_v[k]) first_id = ptr_id[k];
  end

  assign hit  = |hit_vec;
  assign full = &ptr_v;
endmodule

// File: rtl/lpdir_invq.sv
module lpdir_invq #(
  parameter int NPTR   = 4,
  parameter int NODE_W = 6
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        load,
  input  logic [NPTR-1:0]             load_mask,
  input  logic [NPTR-1:0][NODE_W-1:0] load_ids,
  input  logic                        pop,
  output logic                        busy,
  output logic [NODE_W-1:0]           head_id
);
  logic [NPTR-1:0]             mask_q;
  logic [NPTR-1:0][NODE_W-1:0] ids_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '0;
      ids_q  <= '0;
    end else if (load) begin
      mask_q <= load_mask;
      ids_q  <= load_ids;
    end else if (pop) begin
      mask_q <= mask_q & (mask_q - NPTR'(1));
    end
  end

  always_comb begin
    head_id = '0;
    for (int k = NPTR - 1; k >= 0; k--)
      if (mask_q[k]) head_id = ids_q[k];
  end

  assign busy = |mask_q;

  // R4
  pop_busy_chk: assert property (@(posedge clk) disable iff (rst)
    pop |-> busy);

  // R13
  load_idle_chk: assert property (@(posedge clk) disable iff (rst)
    load |-> !busy);

  // R4
  pop_shrink_chk: assert property (@(posedge clk) disable iff (rst)
    (pop && !load) |=> ($countones(mask_q) == $countones($past(mask_q)) - 1));
endmodule

// File: rtl/lpdir_ctrl.sv
module lpdir_ctrl #(
  parameter int NODE_W = 6,
  parameter int BLK_W  = 2,
  parameter int NPTR   = 4,
  parameter int CTR_W  = NODE_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [2:0]        req_kind,
  input  logic [NODE_W-1:0] req_src,
  input  logic [BLK_W-1:0]  req_blk,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [1:0]        out_kind,
  output logic [NODE_W-1:0] out_dst,
  output logic [BLK_W-1:0]  out_blk,
  output logic              trap_pulse,
  output logic              trap_cause,
  output logic [NODE_W-1:0] trap_node,
  output logic [BLK_W-1:0]  trap_blk,
  input  logic              cfg_we,
  input  logic [BLK_W-1:0]  cfg_blk,
  input  logic [1:0]        cfg_state,
  input  logic              cfg_trapmode,
  input  logic [CTR_W-1:0]  cfg_ctr,
  input  logic              cfg_node_en,
  input  logic [NODE_W-1:0] cfg_node
);
  import lpdir_pkg::*;

  localparam int NBLK  = 1 << BLK_W;
  localparam int CNT_W = $clog2(NPTR + 1);

  // per-block directory table
  dir_state_e                  t_state [NBLK];
  logic                        t_trap  [NBLK];
  logic [CTR_W-1:0]            t_ctr   [NBLK];
  logic [NPTR-1:0]             t_pv    [NBLK];
  logic [NPTR-1:0][NODE_W-1:0] t_pid   [NBLK];

  dir_state_e                  cur_state, nx_state;
  logic                        cur_trap;
  logic [CTR_W-1:0]            cur_ctr, nx_ctr;
  logic [NPTR-1:0]             cur_pv, nx_pv;
  logic [NPTR-1:0][NODE_W-1:0] cur_pid, nx_pid;

  logic              hit, full;
  logic [NPTR-1:0]   free_vec, others;
  logic [CNT_W-1:0]  others_cnt;
  logic [NODE_W-1:0] owner;

  logic              accept, o_ld, trap_ld, trap_c, iq_ld, iq_busy, iq_pop;
  msg_kind_e         o_kind;
  logic [NODE_W-1:0] o_dst, iq_head;
  logic [BLK_W-1:0]  inv_blk;

  assign cur_state = t_state[req_blk];
  assign cur_trap  = t_trap[req_blk];
  assign cur_ctr   = t_ctr[req_blk];
  assign cur_pv    = t_pv[req_blk];
  assign cur_pid   = t_pid[req_blk];

  lpdir_ptrs #(.NPTR(NPTR), .NODE_W(NODE_W), .CNT_W(CNT_W)) u_ptrs (
    .ptr_v(cur_pv), .ptr_id(cur_pid), .node(req_src),
    .hit(hit), .free_vec(free_vec), .full(full),
    .others(others), .others_cnt(others_cnt), .first_id(owner)
  );

  lpdir_invq #(.NPTR(NPTR), .NODE_W(NODE_W)) u_invq (
    .clk(clk), .rst(rst), .load(iq_ld && accept), .load_mask(others),
    .load_ids(cur_pid), .pop(iq_pop), .busy(iq_busy), .head_id(iq_head)
  );

  assign req_ready = !cfg_we && !iq_busy && (!out_valid || out_ready);
  assign accept    = req_valid && req_ready;
  assign iq_pop    = iq_busy && (!out_valid || out_ready);

  // next-entry decision for the addressed block
  always_comb begin
    nx_state = cur_state;
    nx_ctr   = cur_ctr;
    nx_pv    = cur_pv;
    nx_pid   = cur_pid;
    o_ld     = 1'b0;
    o_kind   = MS_RDATA;
    o_dst    = req_src;
    trap_ld  = 1'b0;
    trap_c   = 1'b0;
    iq_ld    = 1'b0;
    unique case (cur_state)
      ST_RO: begin
        if (req_kind == RQ_READ) begin
          if (hit) begin
            o_ld = 1'b1;
          end else if (!full) begin
            nx_pv = cur_pv | free_vec;
            for (int k = 0; k < NPTR; k++)
              if (free_vec[k]) nx_pid[k] = req_src;
            o_ld = 1'b1;
          end else begin
            trap_ld = 1'b1;
          end
        end else if (req_kind == RQ_WRITE) begin
          if (cur_trap) begin
            trap_ld = 1'b1;
            trap_c  = 1'b1;
          end else begin
            nx_pv     = NPTR'(1);
            nx_pid[0] = req_src;
            if (others_cnt == '0) begin
              nx_state = ST_RW;
              o_ld     = 1'b1;
              o_kind   = MS_WDATA;
            end else begin
              nx_state = ST_WT;
              nx_ctr   = CTR_W'(others_cnt);
              iq_ld    = 1'b1;
            end
          end
        end
      end
      ST_RW: begin
        if (req_kind == RQ_READ || req_kind == RQ_WRITE) begin
          o_ld = 1'b1;
          if (req_src == owner) begin
            o_kind = (req_kind == RQ_READ) ? MS_RDATA : MS_WDATA;
          end else begin
            o_kind    = MS_INV;
            o_dst     = owner;
            nx_ctr    = CTR_W'(1);
            nx_pv     = NPTR'(1);
            nx_pid[0] = req_src;
            nx_state  = (req_kind == RQ_READ) ? ST_RT : ST_WT;
          end
        end else if (req_kind == RQ_REPLACE && req_src == owner) begin
          nx_pv    = '0;
          nx_state = ST_RO;
        end
      end
      ST_RT, ST_WT: begin
        if (req_kind == RQ_READ || req_kind == RQ_WRITE) begin
          o_ld   = 1'b1;
          o_kind = MS_BUSY;
        end else if (req_kind == RQ_UPDATE || req_kind == RQ_ACK) begin
          if (cur_state == ST_WT && req_kind == RQ_ACK && cur_ctr > CTR_W'(1)) begin
            nx_ctr = cur_ctr - CTR_W'(1);
          end else begin
            o_ld     = 1'b1;
            o_dst    = owner;
            nx_ctr   = '0;
            o_kind   = (cur_state == ST_WT) ? MS_WDATA : MS_RDATA;
            nx_state = (cur_state == ST_WT) ? ST_RW : ST_RO;
          end
        end
      end
      default: ;
    endcase
  end

  // table update
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int b = 0; b < NBLK; b++) begin
        t_state[b] <= ST_RO;
        t_trap[b]  <= 1'b0;
        t_ctr[b]   <= '0;
        t_pv[b]    <= '0;
        t_pid[b]   <= '0;
      end
    end else if (cfg_we) begin
      t_state[cfg_blk]    <= dir_state_e'(cfg_state);
      t_trap[cfg_blk]     <= cfg_trapmode;
      t_ctr[cfg_blk]      <= cfg_ctr;
      t_pv[cfg_blk]       <= cfg_node_en ? NPTR'(1) : '0;
      t_pid[cfg_blk][0]   <= cfg_node;
    end else if (accept) begin
      t_state[req_blk] <= nx_state;
      t_ctr[req_blk]   <= nx_ctr;
      t_pv[req_blk]    <= nx_pv;
      t_pid[req_blk]   <= nx_pid;
    end
  end

  // output stage and trap register
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_kind   <= '0;
      out_dst    <= '0;
      out_blk    <= '0;
      inv_blk    <= '0;
      trap_pulse <= 1'b0;
      trap_cause <= 1'b0;
      trap_node  <= '0;
      trap_blk   <= '0;
    end else begin
      if (accept && o_ld) begin
        out_valid <= 1'b1;
        out_kind  <= o_kind;
        out_dst   <= o_dst;
        out_blk   <= req_blk;
      end else if (iq_pop) begin
        out_valid <= 1'b1;
        out_kind  <= MS_INV;
        out_dst   <= iq_head;
        out_blk   <= inv_blk;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
      if (accept && iq_ld) inv_blk <= req_blk;
      trap_pulse <= accept && trap_ld;
      if (accept && trap_ld) begin
        trap_cause <= trap_c;
        trap_node  <= req_src;
        trap_blk   <= req_blk;
      end
    end
  end

  // R13
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_kind) &&
                                  $stable(out_dst) && $stable(out_blk)));

  // R4
  inv_start_chk: assert property (@(posedge clk) disable iff (rst)
    (accept && iq_ld) |=> (iq_busy && !out_valid && !req_ready));

  // R7
  busy_reply_chk: assert property (@(posedge clk) disable iff (rst)
    (accept && (req_kind == RQ_READ || req_kind == RQ_WRITE) &&
     (cur_state == ST_RT || cur_state == ST_WT)) |=> (out_valid && out_kind == MS_BUSY));

  // R10
  overflow_trap_chk: assert property (@(posedge clk) disable iff (rst)
    (accept && req_kind == RQ_READ && cur_state == ST_RO && !hit && full)
      |=> (trap_pulse && !trap_cause && !out_valid));

  // R11
  trap_on_write_chk: assert property (@(posedge clk) disable iff (rst)
    (accept && req_kind == RQ_WRITE && cur_state == ST_RO && cur_trap)
      |=> (trap_pulse && trap_cause && !out_valid));

  // R12
  cfg_block_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_we |-> !accept);
endmodule

// File: tb/sim_lpdir_ctrl.sv
module sim_lpdir_ctrl;
  localparam int NODE_W = 6;
  localparam int BLK_W  = 2;
  localparam int NPTR   = 4;
  localparam int CTR_W  = NODE_W + 1;
  localparam int NB     = 1 << BLK_W;

  localparam int K_RD = 0, K_WR = 1, K_REP = 2, K_UPD = 3, K_ACK = 4;
  localparam int M_RDATA = 0, M_WDATA = 1, M_INV = 2, M_BUSY = 3;
  localparam int S_RO = 0, S_RW = 1, S_RT = 2, S_WT = 3;

  logic clk = 0, rst = 1;
  logic req_valid = 0, out_ready, cfg_we = 0, cfg_trapmode = 0, cfg_node_en = 0;
  logic req_ready, out_valid, trap_pulse, trap_cause;
  logic [2:0] req_kind = 0;
  logic [NODE_W-1:0] req_src = 0, cfg_node = 0, out_dst, trap_node;
  logic [BLK_W-1:0] req_blk = 0, cfg_blk = 0, out_blk, trap_blk;
  logic [1:0] out_kind, cfg_state = 0;
  logic [CTR_W-1:0] cfg_ctr = 0;

  int total = 0, bad = 0, cyc = 0;
  bit bp = 0, done = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  assign out_ready = !bp || cyc[0];

  lpdir_ctrl #(.NODE_W(NODE_W), .BLK_W(BLK_W), .NPTR(NPTR), .CTR_W(CTR_W)) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .req_src(req_src), .req_blk(req_blk),
    .out_valid(out_valid), .out_ready(out_ready), .out_kind(out_kind),
    .out_dst(out_dst), .out_blk(out_blk), .trap_pulse(trap_pulse),
    .trap_cause(trap_cause), .trap_node(trap_node), .trap_blk(trap_blk),
    .cfg_we(cfg_we), .cfg_blk(cfg_blk), .cfg_state(cfg_state),
    .cfg_trapmode(cfg_trapmode), .cfg_ctr(cfg_ctr), .cfg_node_en(cfg_node_en),
    .cfg_node(cfg_node)
  );

  // reference model
  int m_st[NB], m_tm[NB], m_ctr[NB];
  bit m_pv[NB][NPTR];
  int m_pid[NB][NPTR];
  int eq_kind[$], eq_dst[$], eq_blk[$];
  string eq_tag[$];

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic push(input int k, input int d, input int b, input string tag);
    eq_kind.push_back(k); eq_dst.push_back(d); eq_blk.push_back(b); eq_tag.push_back(tag);
  endtask

  function automatic int owner_of(input int b);
    for (int k = 0; k < NPTR; k++) if (m_pv[b][k]) return m_pid[b][k];
    return -1;
  endfunction

  task automatic only(input int b, input int s);
    for (int k = 0; k < NPTR; k++) m_pv[b][k] = 0;
    m_pv[b][0] = 1; m_pid[b][0] = s;
  endtask

  // imm: 0 nothing, 1 direct reply, 2 invalidation list; tc: -1 or trap cause
  task automatic model(input int k, input int s, input int b,
                       output int imm, output int tc, output string tag);
    int own, n, fr;
    bit hit;
    imm = 0; tc = -1; tag = "R6";
    own = owner_of(b);
    case (m_st[b])
      S_RO: begin
        if (k == K_RD) begin
          hit = 0; fr = -1;
          for (int i = 0; i < NPTR; i++) begin
            if (m_pv[b][i] && m_pid[b][i] == s) hit = 1;
            if (!m_pv[b][i] && fr < 0) fr = i;
          end
          if (hit || fr >= 0) begin
            if (!hit) begin m_pv[b][fr] = 1; m_pid[b][fr] = s; end
            tag = (m_tm[b] != 0) ? "R11" : "R2";
            push(M_RDATA, s, b, tag); imm = 1;
          end else begin
            tag = "R10"; tc = 0;
          end
        end else if (k == K_WR) begin
          if (m_tm[b] != 0) begin
            tag = "R11"; tc = 1;
          end else begin
            n = 0;
            for (int i = 0; i < NPTR; i++)
              if (m_pv[b][i] && m_pid[b][i] != s) begin
                push(M_INV, m_pid[b][i], b, "R4"); n++;
              end
            only(b, s);
            if (n == 0) begin
              tag = "R3"; m_st[b] = S_RW; push(M_WDATA, s, b, tag); imm = 1;
            end else begin
              tag = "R4"; m_st[b] = S_WT; m_ctr[b] = n; imm = 2;
            end
          end
        end
      end
      S_RW: begin
        if (k == K_RD || k == K_WR) begin
          tag = "R5"; imm = 1;
          if (s == own) push(k == K_RD ? M_RDATA : M_WDATA, s, b, tag);
          else begin
            push(M_INV, own, b, tag);
            m_ctr[b] = 1; only(b, s);
            m_st[b] = (k == K_RD) ? S_RT : S_WT;
          end
        end else if (k == K_REP && s == own) begin
          for (int i = 0; i < NPTR; i++) m_pv[b][i] = 0;
          m_st[b] = S_RO;
        end
      end
      default: begin
        if (k == K_RD || k == K_WR) begin
          tag = "R7"; imm = 1; push(M_BUSY, s, b, tag);
        end else if (k == K_REP) begin
          tag = "R7";
        end else if (k == K_UPD || k == K_ACK) begin
          if (m_st[b] == S_WT && k == K_ACK && m_ctr[b] > 1) begin
            tag = "R8"; m_ctr[b]--;
          end else begin
            imm = 1; m_ctr[b] = 0;
            if (m_st[b] == S_WT) begin tag = "R8"; m_st[b] = S_RW; push(M_WDATA, own, b, tag); end
            else begin tag = "R9"; m_st[b] = S_RO; push(M_RDATA, own, b, tag); end
          end
        end
      end
    endcase
  endtask

  task automatic send(input int k, input int s, input int b);
    int imm, tc;
    string tag;
    @(negedge clk);
    req_valid = 1; req_kind = 3'(k); req_src = NODE_W'(s); req_blk = BLK_W'(b);
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    model(k, s, b, imm, tc, tag);
    @(negedge clk);
    req_valid = 0;
    if (imm == 1) check(out_valid === 1'b1, tag, "reply valid one cycle after accept", int'(out_valid), 1);
    else check(out_valid === 1'b0, tag, "no message one cycle after accept", int'(out_valid), 0);
    if (tc >= 0) begin
      check(trap_pulse === 1'b1, tag, "trap pulse", int'(trap_pulse), 1);
      check(int'(trap_cause) == tc, tag, "trap cause", int'(trap_cause), tc);
      check(int'(trap_node) == s && int'(trap_blk) == b, tag, "trap node", int'(trap_node), s);
    end else begin
      check(trap_pulse === 1'b0, tag, "no trap", int'(trap_pulse), 0);
    end
  endtask

  task automatic cfg(input int b, input int st, input int tm, input int ctr,
                     input int nen, input int node);
    @(negedge clk);
    cfg_we = 1; cfg_blk = BLK_W'(b); cfg_state = 2'(st); cfg_trapmode = tm[0];
    cfg_ctr = CTR_W'(ctr); cfg_node_en = nen[0]; cfg_node = NODE_W'(node);
    #1 check(req_ready === 1'b0, "R12", "req_ready low during cfg write", int'(req_ready), 0);
    @(posedge clk);
    m_st[b] = st; m_tm[b] = tm; m_ctr[b] = ctr;
    for (int i = 0; i < NPTR; i++) m_pv[b][i] = 0;
    if (nen != 0) begin m_pv[b][0] = 1; m_pid[b][0] = node; end
    @(negedge clk);
    cfg_we = 0;
  endtask

  // message monitor, compared against the model queue at each falling edge
  always @(negedge clk) begin
    if (!rst && out_valid && out_ready) begin
      if (eq_kind.size() == 0) begin
        check(0, "R13", "unexpected message", int'(out_kind), -1);
      end else begin
        check(int'(out_kind) == eq_kind[0], eq_tag[0], "message kind", int'(out_kind), eq_kind[0]);
        check(int'(out_dst) == eq_dst[0], eq_tag[0], "message destination", int'(out_dst), eq_dst[0]);
        check(int'(out_blk) == eq_blk[0], eq_tag[0], "message block", int'(out_blk), eq_blk[0]);
        void'(eq_kind.pop_front()); void'(eq_dst.pop_front());
        void'(eq_blk.pop_front()); void'(eq_tag.pop_front());
      end
    end
  end

  task automatic drain();
    for (int i = 0; i < 200 && (eq_kind.size() != 0 || out_valid); i++) @(negedge clk);
    check(eq_kind.size() == 0, "R13", "all expected messages delivered", eq_kind.size(), 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int b = 0; b < NB; b++) begin
      m_st[b] = S_RO; m_tm[b] = 0; m_ctr[b] = 0;
      for (int i = 0; i < NPTR; i++) begin m_pv[b][i] = 0; m_pid[b][i] = 0; end
    end
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 0;
    // R1 reset state
    check(out_valid === 1'b0, "R1", "out_valid after reset", int'(out_valid), 0);
    check(trap_pulse === 1'b0, "R1", "trap after reset", int'(trap_pulse), 0);
    check(req_ready === 1'b1, "R1", "req_ready after reset", int'(req_ready), 1);

    // block 0: sharers, overflow trap, trap-on-write, handler path
    send(K_ACK, 3, 0);           // R6 ignored in Read-Only
    send(K_RD, 1, 0); send(K_RD, 2, 0); send(K_RD, 1, 0);
    send(K_RD, 3, 0); send(K_RD, 4, 0);
    send(K_RD, 5, 0);            // R10 overflow
    send(K_RD, 2, 0);            // existing sharer still served
    cfg(0, S_RO, 1, 0, 0, 0);    // R12 handler empties pointers, trap mode
    send(K_RD, 6, 0);            // R11 read serviced in trap mode
    send(K_WR, 7, 0);            // R11 write traps
    cfg(0, S_WT, 0, 2, 1, 7);    // R12 handler sets up write transaction
    send(K_ACK, 6, 0);           // R8 decrement
    send(K_RD, 8, 0);            // R7 busy
    send(K_REP, 6, 0);           // R7 ignored
    send(K_ACK, 6, 0);           // R8 completes, WDATA to 7
    send(K_UPD, 3, 0);           // R6 ignored in Read-Write
    send(K_REP, 3, 0);           // R6 non-owner replace ignored
    send(K_WR, 7, 0);            // R5 owner re-request
    send(K_RD, 9, 0);            // R5 INV to 7, Read-Transaction
    send(K_WR, 10, 0);           // R7 busy
    send(K_UPD, 7, 0);           // R9 RDATA to 9
    send(K_WR, 9, 0);            // R3 sole sharer upgrade
    send(K_REP, 9, 0);           // R6 replace by owner
    send(K_REP, 9, 0);           // R6 now ignored
    send(K_WR, 11, 0);           // R3 empty set
    drain();

    // block 1: multi-target invalidation under back-pressure
    bp = 1;
    send(K_RD, 1, 1); send(K_RD, 2, 1); send(K_RD, 3, 1);
    send(K_WR, 2, 1);            // R4 INV 1 then INV 3, counter 2
    send(K_RD, 20, 3);           // R14 other block served meanwhile
    send(K_ACK, 1, 1);           // R8 decrement
    send(K_RD, 4, 1);            // R7 busy
    send(K_ACK, 3, 1);           // R8 WDATA to 2
    send(K_WR, 5, 1);            // R5 INV to 2, Write-Transaction
    send(K_ACK, 2, 1);           // R8 WDATA to 5
    drain();
    bp = 0;

    // block 3: writer outside the set with one other sharer
    send(K_WR, 6, 3);            // R4 INV to 20
    send(K_UPD, 20, 3);          // R8 update completes
    send(K_RD, 6, 2);            // R14 block 2 untouched so far
    send(K_WR, 6, 2);            // R3
    drain();

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule